// File: doc/BRIEF.md
# Half-Duplex Transmit Pacer

This block decides the cycle in which a half-duplex Ethernet MAC may raise its transmit enable. All of its timers advance on a bit-time tick input, so the same logic serves any line rate. A frame source holds a level request while a frame is waiting and pulses an end marker when the last bit leaves. The pacer turns the request into a transmit window that respects carrier deferral and the inter-frame gap.

On a collision the pacer keeps transmit enable up for a fixed jam period and raises a jam request toward the data path. It then either retries after a binary exponential back-off or abandons the frame. A frame is abandoned when the collision came after the first slot time has gone by. It is also abandoned when the collision limit is reached and a configuration bit allows dropping. Each frame ends with exactly one single-cycle status pulse: done, dropped for excessive collisions, or dropped for a late collision.

The gap is measured from the fall of transmit enable after a clean frame. After a collision, the reference moves to the fall of carrier sense, so a long foreign carrier pushes the next attempt out.

Top module: `hdx_tx_pacer`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_en`, `jam_req`, `frame_done`, `drop_excess` and `drop_late` are all low.
- R2: Transmission never starts while `crs` is high. When a frame is waiting and the gap is already satisfied, `tx_en` rises on the first tick at which `crs` is sampled low.
- R3: After a frame that ended without collision, with a frame waiting, no carrier and a tick every cycle, `tx_en` stays low for exactly IPG_BITS cycles between the two transmissions.
- R4: After a collision, the gap counts from the fall of `crs`. If the back-off is shorter, `tx_en` rises exactly IPG_BITS cycles after `crs` goes low.
- R5: A collision sampled during transmission raises `jam_req` on the next edge. `jam_req` stays high for exactly JAM_BITS ticks, and `tx_en` stays high during the whole jam.
- R6: After the n-th collision of a frame, the pacer waits r·SLOT_BITS ticks before the retry may start, with r drawn from 0 to 2^min(n,BACKOFF_CAP)−1. With a tick every cycle and no carrier, the observed low time of `tx_en` is IPG_BITS when r·SLOT_BITS+1 ≤ IPG_BITS, and r·SLOT_BITS+1 cycles otherwise.
- R7: A collision sampled when at least SLOT_BITS ticks of the frame have elapsed is late. The pacer pulses `drop_late` in the cycle the jam ends and does not back off. A collision after SLOT_BITS−1 ticks is not late and is retried.
- R8: When the ATTEMPT_LIMIT-th collision of a frame has been jammed and `drop_excess_en` is high, `drop_excess` pulses as the jam ends. With `drop_excess_en` low, the frame keeps retrying.
- R9: `frame_end` sampled during transmission with no collision drops `tx_en` on the same edge and pulses `frame_done` for one cycle.
- R10: The collision count returns to zero after every done or drop, so the first collision of the next frame uses a back-off range of 0 to 1 slots.
- R11: The jam, gap, elapsed-time and back-off timers advance only on cycles where `bit_tick` is high.
- R12: At most one status pulse is high in any cycle, and status pulses come out in frame order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle enable per bit time |
| frame_req | input | 1 | A frame is waiting to be sent (level) |
| frame_end | input | 1 | Last bit of the current frame has gone out |
| crs | input | 1 | Carrier sense from the line |
| col | input | 1 | Collision detect from the line |
| drop_excess_en | input | 1 | Abandon a frame once the collision limit is reached |
| tx_en | output | 1 | Transmit enable, high during data and jam |
| jam_req | output | 1 | Data path must send the jam pattern |
| frame_done | output | 1 | Pulse: frame sent without collision |
| drop_excess | output | 1 | Pulse: frame abandoned after too many collisions |
| drop_late | output | 1 | Pulse: frame abandoned after a late collision |

## Verification
The assertions check, on every cycle, properties that hold however the line behaves. Jam is always nested inside transmit enable and lasts the configured number of ticks. No transmission begins under carrier, and no two transmissions are closer than the gap. Status pulses are exclusive, and each one comes at the right edge of a transmission or jam. Only the scenarios can show that the gap reference moves to carrier fall after a collision, and that the random wait stays inside the window that grows with the collision count. They also cover the exact late-collision boundary at one slot, the count being cleared between frames, and the difference between dropping and retrying at the collision limit.

// File: rtl/hdx_pkg.sv
// Shared types for the half-duplex transmit pacer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_JAM  = 2'd2
    } hdx_state_e;

    typedef enum logic [1:0] {
        STAT_NONE   = 2'd0,
        STAT_DONE   = 2'd1,
        STAT_EXCESS = 2'd2,
        STAT_LATE   = 2'd3
    } hdx_status_e;

endpackage

// File: rtl/hdx_ifg_timer.sv
// Inter-frame gap timer. Counts ticks since the last reference point and
// reports when a full gap has gone by. The count restarts while transmit
// enable is high. After a collision (crs_ref high) it also restarts while
// carrier is present, so the gap then runs from the fall of carrier sense.
// Assumes: gap_ok is consumed on a tick edge, so the tick that satisfies it
// is the IPG_BITS-th one. Leaves reset with the gap already satisfied.
module hdx_ifg_timer #(
    parameter int IPG_BITS = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_active,
    input  logic crs,
    input  logic crs_ref,
    output logic gap_ok
);
    localparam int GW = $clog2(IPG_BITS + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(IPG_BITS - 1);

    logic [GW-1:0] gap_cnt;

    // Restart on own transmission or on carrier after a collision, else count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= GAP_FULL;
        end else if (tx_active || (crs_ref && crs)) begin
            gap_cnt <= '0;
        end else if (bit_tick && (gap_cnt < GAP_FULL)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Gap satisfied once the count has reached its last value.
    always_comb gap_ok = (gap_cnt >= GAP_FULL);

endmodule

// File: rtl/hdx_prng.sv
// Free-running Fibonacci LFSR used as the random source for back-off.
// Advances every clock, so the value drawn depends on when the draw occurs.
// Assumes: SEED is nonzero and TAPS gives a maximal-length polynomial.
module hdx_prng #(
    parameter int                WIDTH = 16,
    parameter int                OUT_W = 10,
    parameter logic [WIDTH-1:0]  SEED  = 16'hACE1,
    parameter logic [WIDTH-1:0]  TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [WIDTH-1:0] lfsr_q;
    logic             fb;

    // Feedback is the parity of the tapped bits.
    always_comb fb = ^(lfsr_q & TAPS);

    // Shift one place per clock; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= {lfsr_q[WIDTH-2:0], fb};
        end
    end

    // Low bits form the random draw.
    always_comb rnd = lfsr_q[OUT_W-1:0];

endmodule

// File: rtl/hdx_backoff.sv
// Binary exponential back-off timer. On load it masks the random draw to
// min(attempts, CAP) bits and waits that many slot times, counted in ticks.
// busy is high while slots remain.
// Assumes: load is a single-cycle pulse and attempts is at least 1 on load.
module hdx_backoff #(
    parameter int SLOT_BITS = 512,
    parameter int CAP       = 10,
    parameter int ATT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             load,
    input  logic [ATT_W-1:0] attempts,
    input  logic [CAP-1:0]   rnd,
    output logic             busy
);
    localparam int SW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_BITS - 1);

    logic [CAP-1:0] slots_left;
    logic [SW-1:0]  slot_bit;
    logic [CAP:0]   wide_mask;
    logic [CAP-1:0] draw;
    int             expo;

    // Window exponent is the attempt count capped at CAP; mask keeps that many low bits.
    always_comb begin
        expo      = (int'(attempts) > CAP) ? CAP : int'(attempts);
        wide_mask = ((CAP+1)'(1) << expo) - (CAP+1)'(1);
        draw      = rnd & wide_mask[CAP-1:0];
    end

    // Load the slot count, then step down one slot per SLOT_BITS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_left <= '0;
            slot_bit   <= '0;
        end else if (load) begin
            slots_left <= draw;
            slot_bit   <= '0;
        end else if (bit_tick && (slots_left != '0)) begin
            if (slot_bit == SLOT_LAST) begin
                slot_bit   <= '0;
                slots_left <= slots_left - 1'b1;
            end else begin
                slot_bit <= slot_bit + 1'b1;
            end
        end
    end

    // Busy until the last slot has run out.
    always_comb busy = (slots_left != '0);

endmodule

// File: rtl/hdx_tx_pacer.sv
// Half-duplex transmit pacer. Grants transmit enable when a frame waits,
// carrier is absent, the inter-frame gap is met and no back-off is running.
// A collision forces a jam, then either a back-off retry or a drop (late
// collision, or collision limit reached with dropping enabled).
// Assumes: frame_req stays high until the frame's status pulse; frame_end
// and col are sampled only while sending.
module hdx_tx_pacer #(
    parameter int          IPG_BITS      = 96,
    parameter int          SLOT_BITS     = 512,
    parameter int          JAM_BITS      = 32,
    parameter int          ATTEMPT_LIMIT = 16,
    parameter int          BACKOFF_CAP   = 10,
    parameter int          LFSR_W        = 16,
    parameter logic [15:0] LFSR_SEED     = 16'hACE1,
    parameter logic [15:0] LFSR_TAPS     = 16'hB400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic frame_req,
    input  logic frame_end,
    input  logic crs,
    input  logic col,
    input  logic drop_excess_en,
    output logic tx_en,
    output logic jam_req,
    output logic frame_done,
    output logic drop_excess,
    output logic drop_late
);
    import hdx_pkg::*;

    localparam int ATT_W = $clog2(ATTEMPT_LIMIT + 1);
    localparam int EW    = $clog2(SLOT_BITS + 1);
    localparam int JW    = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
    localparam logic [ATT_W-1:0] ATT_MAX  = ATT_W'(ATTEMPT_LIMIT);
    localparam logic [EW-1:0]    SLOT_LIM = EW'(SLOT_BITS);
    localparam logic [JW-1:0]    JAM_LAST = JW'(JAM_BITS - 1);

    hdx_state_e       state, state_nx;
    logic [EW-1:0]    elapsed;
    logic [JW-1:0]    jam_cnt;
    logic [ATT_W-1:0] attempts;
    logic             late_hit;
    logic             crs_ref;
    logic             gap_ok;
    logic             bo_busy;
    logic             bo_load;
    logic [BACKOFF_CAP-1:0] rnd;

    logic start, col_hit, end_hit, jam_last, give_up_late, give_up_excess;

    hdx_ifg_timer #(.IPG_BITS(IPG_BITS)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .tx_active(tx_en),
        .crs      (crs),
        .crs_ref  (crs_ref),
        .gap_ok   (gap_ok)
    );

    hdx_prng #(
        .WIDTH(LFSR_W),
        .OUT_W(BACKOFF_CAP),
        .SEED (LFSR_W'(LFSR_SEED)),
        .TAPS (LFSR_W'(LFSR_TAPS))
    ) u_prng (
        .clk  (clk),
        .rst_n(rst_n),
        .rnd  (rnd)
    );

    hdx_backoff #(
        .SLOT_BITS(SLOT_BITS),
        .CAP      (BACKOFF_CAP),
        .ATT_W    (ATT_W)
    ) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_tick(bit_tick),
        .load    (bo_load),
        .attempts(attempts),
        .rnd     (rnd),
        .busy    (bo_busy)
    );

    // Event decode: start grant, collision, clean end, jam completion and its outcome.
    always_comb begin
        start          = (state == ST_IDLE) && frame_req && bit_tick && gap_ok
                         && !crs && !bo_busy;
        col_hit        = (state == ST_SEND) && col;
        end_hit        = (state == ST_SEND) && !col && frame_end;
        jam_last       = (state == ST_JAM) && bit_tick && (jam_cnt == JAM_LAST);
        give_up_late   = jam_last && late_hit;
        give_up_excess = jam_last && !late_hit && (attempts == ATT_MAX) && drop_excess_en;
        bo_load        = jam_last && !late_hit && !give_up_excess;
    end

    // Next-state selection; collision wins over a clean end in the same cycle.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_SEND;
            ST_SEND: if (col_hit || end_hit) state_nx = col_hit ? ST_JAM : ST_IDLE;
            ST_JAM:  if (jam_last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Ticks elapsed since the frame began, saturating at one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (start) begin
            elapsed <= '0;
        end else if ((state == ST_SEND) && bit_tick && (elapsed < SLOT_LIM)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Jam length counter, cleared on every collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jam_cnt <= '0;
        end else if (col_hit) begin
            jam_cnt <= '0;
        end else if ((state == ST_JAM) && bit_tick && !jam_last) begin
            jam_cnt <= jam_cnt + 1'b1;
        end
    end

    // Per-frame collision count: saturating increment, cleared when the frame retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attempts <= '0;
        end else if (end_hit || give_up_late || give_up_excess) begin
            attempts <= '0;
        end else if (col_hit && (attempts != ATT_MAX)) begin
            attempts <= attempts + 1'b1;
        end
    end

    // Late flag captured at the collision; gap reference moves to carrier after a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_hit <= 1'b0;
            crs_ref  <= 1'b0;
        end else begin
            if (col_hit) late_hit <= (elapsed >= SLOT_LIM);
            if (col_hit)    crs_ref <= 1'b1;
            else if (start) crs_ref <= 1'b0;
        end
    end

    // Registered single-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done  <= 1'b0;
            drop_excess <= 1'b0;
            drop_late   <= 1'b0;
        end else begin
            frame_done  <= end_hit;
            drop_excess <= give_up_excess;
            drop_late   <= give_up_late;
        end
    end

    // Line controls follow the state directly.
    always_comb begin
        tx_en   = (state != ST_IDLE);
        jam_req = (state == ST_JAM);
    end

endmodule

// File: rtl/hdx_tx_pacer_chk.sv
// Assertion checker for hdx_tx_pacer, attached by bind. Observes ports only
// and keeps its own run-length counters for the gap and jam windows.
module hdx_tx_pacer_chk #(
    parameter int IPG_BITS = 96,
    parameter int JAM_BITS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic crs,
    input logic col,
    input logic drop_excess_en,
    input logic tx_en,
    input logic jam_req,
    input logic frame_done,
    input logic drop_excess,
    input logic drop_late
);
    localparam int IW = $clog2(IPG_BITS + 1);
    localparam int JW = $clog2(JAM_BITS + 1) + 1;

    logic [IW-1:0] idle_run;
    logic [JW-1:0] jam_ticks;

    // Cycles with transmit enable low, saturating at the gap length.
    always_ff @(posedge clk) begin
        if (!rst_n)                         idle_run <= IW'(IPG_BITS);
        else if (tx_en)                     idle_run <= '0;
        else if (idle_run < IW'(IPG_BITS))  idle_run <= idle_run + 1'b1;
    end

    // Ticks seen while jam is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)       jam_ticks <= '0;
        else if (jam_req) jam_ticks <= jam_ticks + JW'(bit_tick);
        else              jam_ticks <= '0;
    end

    a_r2_no_start_under_crs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> !$past(crs));

    a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (idle_run >= IW'(IPG_BITS)));

    a_r5_jam_inside_tx: assert property (@(posedge clk) disable iff (!rst_n)
        jam_req |-> tx_en);

    a_r5_col_starts_jam: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !jam_req && col) |=> jam_req);

    a_r5_jam_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jam_req) |-> (jam_ticks == JW'(JAM_BITS)));

    a_r7_late_at_jam_end: assert property (@(posedge clk) disable iff (!rst_n)
        drop_late |-> ($past(jam_req) && !tx_en));

    a_r8_excess_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        drop_excess |-> ($past(drop_excess_en) && $past(jam_req) && !tx_en));

    a_r9_done_ends_send: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($past(tx_en) && !$past(jam_req) && !tx_en));

    a_r12_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_done, drop_excess, drop_late}));

endmodule

bind hdx_tx_pacer hdx_tx_pacer_chk #(
    .IPG_BITS(IPG_BITS),
    .JAM_BITS(JAM_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .crs           (crs),
    .col           (col),
    .drop_excess_en(drop_excess_en),
    .tx_en         (tx_en),
    .jam_req       (jam_req),
    .frame_done    (frame_done),
    .drop_excess   (drop_excess),
    .drop_late     (drop_late)
);

// File: tb/hdx_tx_pacer_bench.sv
// Scoreboard bench: scenario tasks push expected status codes into a queue,
// a monitor pops and compares them as status pulses appear.
module hdx_tx_pacer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IPG   = 96;
    localparam int SLOT  = 64;
    localparam int JAM   = 32;
    localparam int LIMIT = 16;
    localparam int CAP   = 4;
    localparam int LOW_GUARD = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic tick_half = 1'b0;
    logic frame_req = 1'b0;
    logic frame_end = 1'b0;
    logic col = 1'b0;
    logic drop_excess_en = 1'b0;
    logic ext_busy = 1'b0;
    logic crs;
    logic tx_en, jam_req, frame_done, drop_excess, drop_late;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];

    assign crs = tx_en | ext_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdx_tx_pacer #(
        .IPG_BITS(IPG), .SLOT_BITS(SLOT), .JAM_BITS(JAM),
        .ATTEMPT_LIMIT(LIMIT), .BACKOFF_CAP(CAP)
    ) u_hdx_tx_pacer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_req(frame_req),
        .frame_end(frame_end), .crs(crs), .col(col), .drop_excess_en(drop_excess_en),
        .tx_en(tx_en), .jam_req(jam_req), .frame_done(frame_done),
        .drop_excess(drop_excess), .drop_late(drop_late)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Tick source: every cycle, or every other cycle when tick_half is set.
    always @(negedge clk) bit_tick <= tick_half ? ~bit_tick : 1'b1;

    // Monitor: pop expected status codes (1 done, 2 excess, 3 late) and compare.
    always @(negedge clk) begin
        if (rst_n) begin
            int code;
            code = frame_done ? 1 : (drop_excess ? 2 : (drop_late ? 3 : 0));
            if (int'(frame_done) + int'(drop_excess) + int'(drop_late) > 1)
                check(1'b0, "R12 single status", 2, 1);
            if (code != 0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected status", code, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(code == e, (e == 1) ? "R9 status" : (e == 2) ? "R8 status" : "R7 status",
                          code, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic wait_tx_high();
        int g = 0;
        while (!tx_en && g < LOW_GUARD) begin g++; @(negedge clk); end
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!tx_en && n < LOW_GUARD) begin n++; @(negedge clk); end
    endtask

    task automatic end_frame();
        exp_q.push_back(1);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        check(!tx_en, "R9 tx_en falls on frame end", int'(tx_en), 0);
    endtask

    task automatic collide(output int jam_len);
        col = 1'b1;
        @(negedge clk);
        col = 1'b0;
        check(jam_req && tx_en, "R5 jam follows collision", int'(jam_req), 1);
        jam_len = 0;
        while (jam_req) begin
            if (!tx_en) check(1'b0, "R5 tx_en held in jam", 0, 1);
            jam_len++;
            @(negedge clk);
        end
    endtask

    function automatic bit backoff_ok(input int n, input int low);
        int maxr;
        maxr = (1 << ((n > CAP) ? CAP : n)) - 1;
        return (low == IPG) || ((low > IPG) && ((low - 1) % SLOT == 0) && ((low - 1) / SLOT <= maxr));
    endfunction

    initial begin
        int low, jl;
        // R1: reset state, with a request already pending.
        frame_req = 1'b1;
        repeat (5) @(negedge clk);
        check(!tx_en && !jam_req && !frame_done && !drop_excess && !drop_late,
              "R1 outputs in reset", int'(tx_en), 0);
        rst_n = 1'b1;
        frame_req = 1'b0;
        @(negedge clk);
        check(!tx_en && !jam_req && !frame_done && !drop_excess && !drop_late,
              "R1 outputs after reset", int'(tx_en), 0);

        // R3, R9: two back-to-back clean frames.
        frame_req = 1'b1;
        wait_tx_high();
        repeat (50) @(negedge clk);
        end_frame();
        measure_low(low);
        check(low == IPG, "R3 gap after clean frame", low, IPG);
        repeat (40) @(negedge clk);
        frame_req = 1'b0;
        end_frame();

        // R2: deferral under foreign carrier.
        repeat (150) @(negedge clk);
        ext_busy = 1'b1;
        frame_req = 1'b1;
        repeat (20) @(negedge clk);
        check(!tx_en, "R2 no start under crs", int'(tx_en), 0);
        ext_busy = 1'b0;
        measure_low(low);
        check(low == 1, "R2 start on first tick after crs falls", low, 1);

        // R4, R5: collision with carrier held long after the jam.
        repeat (20) @(negedge clk);
        ext_busy = 1'b1;
        collide(jl);
        check(jl == JAM, "R5 jam length", jl, JAM);
        repeat (150) @(negedge clk);
        check(!tx_en, "R4 held off by carrier", int'(tx_en), 0);
        ext_busy = 1'b0;
        measure_low(low);
        check(low == IPG, "R4 gap from crs fall", low, IPG);
        repeat (30) @(negedge clk);
        frame_req = 1'b0;
        end_frame();

        // R6: back-off window grows with the collision count.
        repeat (120) @(negedge clk);
        frame_req = 1'b1;
        for (int n = 1; n <= 5; n++) begin
            wait_tx_high();
            repeat (10) @(negedge clk);
            collide(jl);
            measure_low(low);
            check(backoff_ok(n, low), $sformatf("R6 back-off window n=%0d", n), low, IPG);
        end
        repeat (20) @(negedge clk);
        frame_req = 1'b0;
        end_frame();

        // R7: late boundary, one tick before and at one slot.
        repeat (120) @(negedge clk);
        frame_req = 1'b1;
        wait_tx_high();
        repeat (SLOT - 1) @(negedge clk);
        collide(jl);
        check(!drop_late, "R7 collision before slot retried", int'(drop_late), 0);
        measure_low(low);
        check(backoff_ok(1, low), "R7 early collision backs off", low, IPG);
        repeat (SLOT) @(negedge clk);
        exp_q.push_back(3);
        collide(jl);
        frame_req = 1'b0;
        check(drop_late, "R7 late collision dropped", int'(drop_late), 1);
        repeat (200) @(negedge clk);
        check(!tx_en, "R7 no retry after late drop", int'(tx_en), 0);

        // R10: the count is cleared, so the first collision uses a 0..1 slot window.
        frame_req = 1'b1;
        wait_tx_high();
        repeat (10) @(negedge clk);
        collide(jl);
        measure_low(low);
        check(low == IPG, "R10 count cleared after drop", low, IPG);
        repeat (20) @(negedge clk);
        frame_req = 1'b0;
        end_frame();

        // R8: drop at the limit when enabled.
        repeat (120) @(negedge clk);
        drop_excess_en = 1'b1;
        frame_req = 1'b1;
        for (int n = 1; n <= LIMIT; n++) begin
            wait_tx_high();
            repeat (5) @(negedge clk);
            if (n == LIMIT) exp_q.push_back(2);
            collide(jl);
            if (n < LIMIT) begin
                check(!drop_excess, "R8 no drop below limit", int'(drop_excess), 0);
                measure_low(low);
                check(backoff_ok(n, low), "R6 back-off under repeated collisions", low, IPG);
            end else begin
                frame_req = 1'b0;
                check(drop_excess, "R8 drop at limit", int'(drop_excess), 1);
            end
        end

        // R8: keep retrying at the limit when disabled.
        repeat (120) @(negedge clk);
        drop_excess_en = 1'b0;
        frame_req = 1'b1;
        for (int n = 1; n <= LIMIT; n++) begin
            wait_tx_high();
            repeat (5) @(negedge clk);
            collide(jl);
            measure_low(low);
        end
        check(tx_en, "R8 retry past limit when not dropping", int'(tx_en), 1);
        repeat (20) @(negedge clk);
        frame_req = 1'b0;
        end_frame();

        // R11: with a tick every other cycle the jam takes twice as many cycles.
        repeat (120) @(negedge clk);
        tick_half = 1'b1;
        frame_req = 1'b1;
        wait_tx_high();
        repeat (10) @(negedge clk);
        collide(jl);
        check(jl >= 2*JAM - 1 && jl <= 2*JAM, "R11 jam counts ticks only", jl, 2*JAM);
        tick_half = 1'b0;
        wait_tx_high();
        repeat (20) @(negedge clk);
        frame_req = 1'b0;
        end_frame();

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R12 all expected statuses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule